// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is the control unit and datapath of a small 16-bit accumulator machine. It owns the program counter, the memory address register, the instruction register, the accumulator and the zero/negative flags. It drives one 8-bit word address, a 16-bit write word and a write strobe toward an external single-port memory, and it reads that memory through a combinational read-data input. The ALU is a separate submodule, and a finite-state controller steps every instruction through fetch, decode and an execute phase whose shape depends on the instruction class.

Each instruction is one 16-bit word. The upper byte is the operation code and the lower byte is an absolute word address. Load-immediate is the only exception: it takes its operand from the word after the instruction and then skips that word. Stores are stretched. The address and data are shown for a configurable number of cycles before a one-cycle write strobe and held for a configurable number of cycles after it. The memory side has no flow control: the core assumes the memory answers a read within the cycle its address is presented and accepts a write in the strobe cycle, so there is no valid/ready pair and no back-pressure.

Top module: `acc_cpu_core`

## Requirements
- R1: While the synchronous active-high reset is applied, the core clears PC, MAR, IR, accumulator and flags. From the next edge `mem_addr` is 0x00, `mem_wdata` is 0x0000 and `mem_we` is 0. After reset the first fetch reads word 0x00.
- R2: Every instruction starts with one fetch cycle that captures the word at MAR into IR and adds one to PC. Arithmetic, logic, load and load-immediate instructions take 3 cycles. Complement, jumps and unknown codes take 2 cycles. A store takes 3 + setup + hold cycles. For the program used in the checks, the first write strobe is high in cycle 10 after reset is released.
- R3: Operation codes are add 0x00, saturating add 0x01, subtract 0x02, saturating subtract 0x03, AND 0x04, complement 0x05, load 0x06, load-immediate 0x07, store 0x08, jump 0x09 and jump-if-zero 0x0A, all in bits 15:8. The operand address is in bits 7:0. Add and subtract wrap modulo 2^16. AND, complement and load replace the accumulator with the expected value.
- R4: Saturating add and saturating subtract treat the operands as two's complement. A result that would exceed 0x7FFF becomes 0x7FFF, and one below 0x8000 becomes 0x8000.
- R5: Load-immediate loads the word that follows the instruction and resumes execution at the word after that.
- R6: Jump continues execution at the address in bits 7:0, with no execute cycle.
- R7: Jump-if-zero continues at its target when Z is 1. When Z is 0 it continues at the next word.
- R8: Z (result equals zero) and N (result bit 15) are updated only by the arithmetic, AND, complement, load and load-immediate instructions. Store and both jumps leave them unchanged.
- R9: A store keeps the operand address on `mem_addr` and the accumulator on `mem_wdata` for the whole store. This covers at least one cycle before `mem_we` rises, exactly one cycle with `mem_we` high, and at least one cycle after it falls. Each store gives exactly one strobe.
- R10: An operation code outside 0x00 to 0x0A changes no architectural state other than advancing PC by one.
- R11: A stored Fibonacci program climbs from 0 with saturating addition until the sum saturates and then walks back down. It shows the sequence 0, 1, 1, 2, 3, ..., 28657 and then 28657, 17711, ..., 2, 1 through writes to word 0xFF, repeating endlessly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 16 | Word read from memory at `mem_addr`, valid in the same cycle |
| mem_addr | output | 8 | Word address, driven from MAR |
| mem_wdata | output | 16 | Store data, driven from the accumulator |
| mem_we | output | 1 | Write strobe, high for one cycle per store |

## Verification
Two pairs of functions share a single cycle. In the execute cycle of load-immediate, the accumulator load, the flag update, the PC skip and the reload of MAR all happen at the same edge. This is provoked by placing a store directly after a load-immediate and a jump-if-zero right after another one, and judged by the stored value and by which later store appears. In the last hold cycle of a store, MAR reloads from PC at the edge that ends the store, while the address must still show the store target. The scoreboard compares every strobe with the expected address and data. The monitor also checks that address and data are unchanged one cycle before the strobe and one cycle after it, and the Fibonacci run exercises this back-to-back across many store-then-load sequences.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 8;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD  = 8'h00,
    OPC_ADDS = 8'h01,
    OPC_SUB  = 8'h02,
    OPC_SUBS = 8'h03,
    OPC_AND  = 8'h04,
    OPC_COM  = 8'h05,
    OPC_LW   = 8'h06,
    OPC_LDI  = 8'h07,
    OPC_SW   = 8'h08,
    OPC_JMP  = 8'h09,
    OPC_JMPZ = 8'h0A
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_SETUP,
    ST_WRITE,
    ST_HOLD
  } phase_e;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_ADDS,
    ALU_SUB,
    ALU_SUBS,
    ALU_AND,
    ALU_COM,
    ALU_PASS
  } alu_op_e;

  typedef enum logic [1:0] {
    MAR_KEEP,
    MAR_FIELD,
    MAR_PC,
    MAR_PC_NEXT
  } mar_src_e;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         res_zero,
  output logic         res_neg
);

  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sum;
  logic [W-1:0] dif;
  logic         sum_ovf;
  logic         dif_ovf;

  assign sum     = lhs + rhs;
  assign dif     = lhs - rhs;
  assign sum_ovf = (lhs[W-1] == rhs[W-1]) && (sum[W-1] != lhs[W-1]);
  assign dif_ovf = (lhs[W-1] != rhs[W-1]) && (dif[W-1] != lhs[W-1]);

  always_comb begin
    case (op)
      ALU_ADD:  res = sum;
      ALU_ADDS: res = sum_ovf ? (lhs[W-1] ? NEG_LIM : POS_LIM) : sum;
      ALU_SUB:  res = dif;
      ALU_SUBS: res = dif_ovf ? (lhs[W-1] ? NEG_LIM : POS_LIM) : dif;
      ALU_AND:  res = lhs & rhs;
      ALU_COM:  res = ~lhs;
      default:  res = rhs;
    endcase
  end

  assign res_zero = (res == '0);
  assign res_neg  = res[W-1];

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opc,
  input  logic             zflag,
  output phase_e           phase,
  output logic             ir_ld,
  output logic             pc_inc,
  output logic             pc_jump,
  output mar_src_e         mar_src,
  output logic             acc_ld,
  output logic             flag_ld,
  output alu_op_e          alu_op,
  output logic             wr_en
);

  localparam int CNT_MAX = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
  localparam int CNT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);

  phase_e            phase_q;
  phase_e            phase_d;
  logic [CNT_W-1:0]  dwell_q;

  assign phase = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= ST_FETCH;
      dwell_q <= '0;
    end else begin
      phase_q <= phase_d;
      dwell_q <= (phase_d != phase_q) ? '0 : dwell_q + 1'b1;
    end
  end

  always_comb begin
    phase_d = phase_q;
    ir_ld   = 1'b0;
    pc_inc  = 1'b0;
    pc_jump = 1'b0;
    mar_src = MAR_KEEP;
    acc_ld  = 1'b0;
    flag_ld = 1'b0;
    alu_op  = ALU_PASS;
    wr_en   = 1'b0;
    case (phase_q)
      ST_FETCH: begin
        ir_ld   = 1'b1;
        pc_inc  = 1'b1;
        phase_d = ST_DECODE;
      end
      ST_DECODE: begin
        case (opc)
          OPC_ADD, OPC_ADDS, OPC_SUB, OPC_SUBS, OPC_AND, OPC_LW: begin
            mar_src = MAR_FIELD;
            phase_d = ST_EXEC;
          end
          OPC_LDI: begin
            mar_src = MAR_PC;
            phase_d = ST_EXEC;
          end
          OPC_COM: begin
            alu_op  = ALU_COM;
            acc_ld  = 1'b1;
            flag_ld = 1'b1;
            mar_src = MAR_PC;
            phase_d = ST_FETCH;
          end
          OPC_SW: begin
            mar_src = MAR_FIELD;
            phase_d = ST_SETUP;
          end
          OPC_JMP: begin
            pc_jump = 1'b1;
            mar_src = MAR_FIELD;
            phase_d = ST_FETCH;
          end
          OPC_JMPZ: begin
            pc_jump = zflag;
            mar_src = zflag ? MAR_FIELD : MAR_PC;
            phase_d = ST_FETCH;
          end
          default: begin
            mar_src = MAR_PC;
            phase_d = ST_FETCH;
          end
        endcase
      end
      ST_EXEC: begin
        acc_ld  = 1'b1;
        flag_ld = 1'b1;
        case (opc)
          OPC_ADD:  alu_op = ALU_ADD;
          OPC_ADDS: alu_op = ALU_ADDS;
          OPC_SUB:  alu_op = ALU_SUB;
          OPC_SUBS: alu_op = ALU_SUBS;
          OPC_AND:  alu_op = ALU_AND;
          default:  alu_op = ALU_PASS;
        endcase
        if (opc == OPC_LDI) begin
          pc_inc  = 1'b1;
          mar_src = MAR_PC_NEXT;
        end else begin
          mar_src = MAR_PC;
        end
        phase_d = ST_FETCH;
      end
      ST_SETUP: begin
        if (dwell_q == SETUP_LAST) phase_d = ST_WRITE;
      end
      ST_WRITE: begin
        wr_en   = 1'b1;
        phase_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (dwell_q == HOLD_LAST) begin
          mar_src = MAR_PC;
          phase_d = ST_FETCH;
        end
      end
      default: phase_d = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int SETUP_CYC = 1,
  parameter int HOLD_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we
);

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q;
  logic              zf_q;
  logic              nf_q;

  phase_e            phase;
  logic              ir_ld;
  logic              pc_inc;
  logic              pc_jump;
  mar_src_e          mar_src;
  logic              acc_ld;
  logic              flag_ld;
  alu_op_e           alu_op;
  logic              wr_en;

  logic [DATA_W-1:0] alu_res;
  logic              alu_zero;
  logic              alu_neg;
  logic [ADDR_W-1:0] field;
  logic [ADDR_W-1:0] pc_plus;

  assign field   = ir_q[ADDR_W-1:0];
  assign pc_plus = pc_q + 1'b1;

  acc_cpu_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC (HOLD_CYC)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opc    (ir_q[DATA_W-1 -: OPC_W]),
    .zflag  (zf_q),
    .phase  (phase),
    .ir_ld  (ir_ld),
    .pc_inc (pc_inc),
    .pc_jump(pc_jump),
    .mar_src(mar_src),
    .acc_ld (acc_ld),
    .flag_ld(flag_ld),
    .alu_op (alu_op),
    .wr_en  (wr_en)
  );

  acc_cpu_alu #(
    .W(DATA_W)
  ) u_alu (
    .lhs     (acc_q),
    .rhs     (mem_rdata),
    .op      (alu_op),
    .res     (alu_res),
    .res_zero(alu_zero),
    .res_neg (alu_neg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      ir_q  <= '0;
      acc_q <= '0;
      zf_q  <= 1'b0;
      nf_q  <= 1'b0;
    end else begin
      if (ir_ld) ir_q <= mem_rdata;
      if (pc_jump)     pc_q <= field;
      else if (pc_inc) pc_q <= pc_plus;
      case (mar_src)
        MAR_FIELD:   mar_q <= field;
        MAR_PC:      mar_q <= pc_q;
        MAR_PC_NEXT: mar_q <= pc_plus;
        default:     mar_q <= mar_q;
      endcase
      if (acc_ld) acc_q <= alu_res;
      if (flag_ld) begin
        zf_q <= alu_zero;
        nf_q <= alu_neg;
      end
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = acc_q;
  assign mem_we    = wr_en;

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              ir_ld,
  input logic              flag_ld,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] ir_q,
  input logic [DATA_W-1:0] acc_q,
  input logic              zf_q,
  input logic              nf_q
);

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  assert_store_setup_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  assert_store_hold_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (rst)
    ir_ld |=> (pc_q == $past(pc_q) + 1'b1));

  assert_ir_steady_R2: assert property (@(posedge clk) disable iff (rst)
    !ir_ld |=> $stable(ir_q));

  assert_flags_track_R8: assert property (@(posedge clk) disable iff (rst)
    flag_ld |=> ((zf_q == (acc_q == '0)) && (nf_q == acc_q[DATA_W-1])));

  assert_store_keeps_flags_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> ($stable(zf_q) && $stable(nf_q)));

endmodule

bind acc_cpu_core acc_cpu_chk #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata),
  .ir_ld    (ir_ld),
  .flag_ld  (flag_ld),
  .pc_q     (pc_q),
  .ir_q     (ir_q),
  .acc_q    (acc_q),
  .zf_q     (zf_q),
  .nf_q     (nf_q)
);

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0]  a;
    logic [15:0] d;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] mem_rdata;
  logic [7:0]  mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;

  logic [15:0] prog [256];
  logic [15:0] ram  [256];
  logic [255:0] touched;

  int   n_chk = 0;
  int   n_err = 0;
  exp_t exp_q[$];
  bit   only_ff = 1'b0;
  int   ecnt = 0;
  int   first_we = -1;
  logic [7:0]  p_addr = '0;
  logic [15:0] p_data = '0;
  logic        p_we = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu_core u_dut (
    .clk      (clk),
    .rst      (rst),
    .mem_rdata(mem_rdata),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_we   (mem_we)
  );

  assign mem_rdata = touched[mem_addr] ? ram[mem_addr] : prog[mem_addr];

  always @(posedge clk) begin
    if (rst) begin
      touched <= '0;
      ecnt    <= 0;
    end else begin
      ecnt <= ecnt + 1;
      if (mem_we) begin
        ram[mem_addr]     <= mem_wdata;
        touched[mem_addr] <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] a, input logic [15:0] d, input string tag);
    exp_t e;
    e.a = a; e.d = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: pops the scoreboard on each strobe and judges store framing (R9)
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we && !p_we) begin
        if (first_we < 0) first_we = ecnt;
        chk(mem_addr == p_addr && mem_wdata == p_data, "R9 setup stability",
            {mem_addr, 8'h0, mem_wdata}, {p_addr, 8'h0, p_data});
        if (!only_ff || mem_addr == 8'hFF) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 R7 R10 unexpected store", {8'h0, mem_addr, mem_wdata}, 32'h0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(mem_addr == e.a && mem_wdata == e.d, e.tag,
                {8'h0, mem_addr, mem_wdata}, {8'h0, e.a, e.d});
          end
        end
      end
      if (mem_we && p_we)
        chk(1'b0, "R9 strobe longer than one cycle", 32'd2, 32'd1);
      if (!mem_we && p_we)
        chk(mem_addr == p_addr && mem_wdata == p_data, "R9 hold stability",
            {mem_addr, 8'h0, mem_wdata}, {p_addr, 8'h0, p_data});
    end
    p_addr = mem_addr;
    p_data = mem_wdata;
    p_we   = mem_we;
  end

  function automatic logic [15:0] ins(input logic [7:0] op, input logic [7:0] a);
    return {op, a};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
  endtask

  task automatic load_prog_a();
    clear_prog();
    prog[8'h80] = 16'h1234; prog[8'h81] = 16'h0F0F; prog[8'h82] = 16'h7FF0;
    prog[8'h83] = 16'h0020; prog[8'h84] = 16'h8010; prog[8'h85] = 16'hFFFF;
    prog[8'h00] = ins(8'h06, 8'h80); prog[8'h01] = ins(8'h00, 8'h81);
    prog[8'h02] = ins(8'h08, 8'h90); prog[8'h03] = ins(8'h04, 8'h81);
    prog[8'h04] = ins(8'h08, 8'h91); prog[8'h05] = ins(8'h02, 8'h80);
    prog[8'h06] = ins(8'h08, 8'h92); prog[8'h07] = ins(8'h05, 8'h00);
    prog[8'h08] = ins(8'h08, 8'h93); prog[8'h09] = ins(8'h06, 8'h82);
    prog[8'h0A] = ins(8'h01, 8'h83); prog[8'h0B] = ins(8'h08, 8'h94);
    prog[8'h0C] = ins(8'h06, 8'h82); prog[8'h0D] = ins(8'h00, 8'h83);
    prog[8'h0E] = ins(8'h08, 8'h95); prog[8'h0F] = ins(8'h06, 8'h84);
    prog[8'h10] = ins(8'h03, 8'h83); prog[8'h11] = ins(8'h08, 8'h96);
    prog[8'h12] = ins(8'h02, 8'h83); prog[8'h13] = ins(8'h08, 8'h97);
    prog[8'h14] = ins(8'h07, 8'h00); prog[8'h15] = 16'hBEEF;
    prog[8'h16] = ins(8'h08, 8'h98); prog[8'h17] = ins(8'hEE, 8'h00);
    prog[8'h18] = ins(8'h08, 8'h99); prog[8'h19] = ins(8'h09, 8'h1B);
    prog[8'h1A] = ins(8'h08, 8'h9A); prog[8'h1B] = ins(8'h06, 8'h85);
    prog[8'h1C] = ins(8'h05, 8'h00); prog[8'h1D] = ins(8'h08, 8'h9B);
    prog[8'h1E] = ins(8'h0A, 8'h20); prog[8'h1F] = ins(8'h08, 8'h9C);
    prog[8'h20] = ins(8'h07, 8'h00); prog[8'h21] = 16'h0005;
    prog[8'h22] = ins(8'h0A, 8'h24); prog[8'h23] = ins(8'h08, 8'h9D);
    prog[8'h24] = ins(8'h09, 8'h24);
  endtask

  task automatic load_prog_fib();
    clear_prog();
    prog[8'h00] = ins(8'h07, 8'h00); prog[8'h01] = 16'h0000;
    prog[8'h02] = ins(8'h08, 8'h80); prog[8'h03] = ins(8'h08, 8'hFF);
    prog[8'h04] = ins(8'h07, 8'h00); prog[8'h05] = 16'h0001;
    prog[8'h06] = ins(8'h08, 8'h81); prog[8'h07] = ins(8'h08, 8'hFF);
    prog[8'h08] = ins(8'h06, 8'h80); prog[8'h09] = ins(8'h01, 8'h81);
    prog[8'h0A] = ins(8'h08, 8'h82); prog[8'h0B] = ins(8'h07, 8'h00);
    prog[8'h0C] = 16'h7FFF;          prog[8'h0D] = ins(8'h02, 8'h82);
    prog[8'h0E] = ins(8'h0A, 8'h16); prog[8'h0F] = ins(8'h06, 8'h81);
    prog[8'h10] = ins(8'h08, 8'h80); prog[8'h11] = ins(8'h06, 8'h82);
    prog[8'h12] = ins(8'h08, 8'h81); prog[8'h13] = ins(8'h08, 8'hFF);
    prog[8'h14] = ins(8'h09, 8'h08);
    prog[8'h16] = ins(8'h06, 8'h81); prog[8'h17] = ins(8'h08, 8'hFF);
    prog[8'h18] = ins(8'h03, 8'h80); prog[8'h19] = ins(8'h08, 8'h82);
    prog[8'h1A] = ins(8'h0A, 8'h00); prog[8'h1B] = ins(8'h06, 8'h80);
    prog[8'h1C] = ins(8'h08, 8'h81); prog[8'h1D] = ins(8'h06, 8'h82);
    prog[8'h1E] = ins(8'h08, 8'h80); prog[8'h1F] = ins(8'h09, 8'h16);
  endtask

  task automatic check_reset_state(input string tag);
    chk(mem_addr == 8'h00, {tag, " R1 address"}, {24'h0, mem_addr}, 32'h0);
    chk(mem_we == 1'b0, {tag, " R1 strobe"}, {31'h0, mem_we}, 32'h0);
    chk(mem_wdata == 16'h0000, {tag, " R1 accumulator"}, {16'h0, mem_wdata}, 32'h0);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R11 watchdog expired with %0d stores pending", exp_q.size());
    summary();
    $finish;
  end

  initial begin
    int fib [24];
    fib[0] = 0;
    fib[1] = 1;
    for (int k = 2; k < 24; k++) fib[k] = fib[k-1] + fib[k-2];

    // Directed program: arithmetic, saturation, immediate, jumps, unknown code
    load_prog_a();
    only_ff  = 1'b0;
    first_we = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("power-up");
    push(8'h90, 16'h2143, "R3 add wraps");
    push(8'h91, 16'h0103, "R3 and");
    push(8'h92, 16'hEECF, "R3 sub wraps below zero");
    push(8'h93, 16'h1130, "R3 complement");
    push(8'h94, 16'h7FFF, "R4 saturating add clamps high");
    push(8'h95, 16'h8010, "R3 plain add overflows");
    push(8'h96, 16'h8000, "R4 saturating sub clamps low");
    push(8'h97, 16'h7FE0, "R3 plain sub overflows");
    push(8'h98, 16'hBEEF, "R5 load-immediate operand");
    push(8'h99, 16'hBEEF, "R10 unknown code keeps accumulator");
    push(8'h9B, 16'h0000, "R6 jump target reached");
    push(8'h9D, 16'h0005, "R7 jump-if-zero falls through, R8 store kept Z");
    rst = 1'b0;
    for (int i = 0; i < 800 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (60) @(negedge clk);
    chk(exp_q.size() == 0, "R3 R8 all directed stores seen", exp_q.size(), 32'd0);
    chk(first_we == 9, "R2 first strobe cycle", first_we, 32'd9);

    // Reset taken mid-run with a nonzero accumulator
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset_state("mid-run");

    // Fibonacci climb and descent, two full rounds on word 0xFF
    load_prog_fib();
    exp_q.delete();
    only_ff = 1'b1;
    for (int r = 0; r < 2; r++) begin
      push(8'hFF, 16'h0000, "R11 start value 0");
      push(8'hFF, 16'h0001, "R11 start value 1");
      for (int k = 2; k < 24; k++) push(8'hFF, 16'(fib[k]), "R11 climbing");
      for (int k = 23; k >= 2; k--) push(8'hFF, 16'(fib[k]), "R11 descending");
    end
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 20000 && exp_q.size() != 0; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R11 full sequence displayed", exp_q.size(), 32'd0);

    summary();
    $finish;
  end

endmodule